// File: doc/BRIEF.md
# Four-Register Single-Cycle Datapath Core

This block is the storage and bus-steering half of a single-cycle datapath. It keeps four W-bit registers and, from one control word, routes two of them to the operand buses of an external function unit, optionally replaces the second operand with a constant, and chooses what is written back: the function unit's result or an external data word. Because reads are combinational and the only state change is the write at the rising edge, a whole source-to-unit-to-destination transfer finishes in one clock.

The function unit (arithmetic, logic, shifting) lives outside. It takes `opa_bus` and `opb_bus`, returns `unit_result`, and receives the function-select code unchanged through `unit_op`. Storage resets synchronously to zero.

Top module: `sc_regpath`

## Requirements
- R1: While `rst` is high at a rising edge, all four registers become zero after that edge.
- R2: `opa_bus` always shows the register addressed by the A-select field `ctl[6:5]`, with no clock involved.
- R3: With the constant-select bit `ctl[2]` low, `opb_bus` shows the register addressed by the B-select field `ctl[4:3]`; with it high, `opb_bus` equals `const_in`.
- R4: With the external-select bit `ctl[1]` high, `wb_bus` equals `ext_in`; with it low, `wb_bus` equals `unit_result`.
- R5: When the write bit `ctl[0]` is high at a rising edge (reset low), the register addressed by the destination field `ctl[8:7]` takes the `wb_bus` value.
- R6: A register not addressed for writing, or any register when `ctl[0]` is low, keeps its value across the edge.
- R7: A register that is read and written in the same cycle shows its old value on the buses until the edge and the new value after it.
- R8: `unit_op` equals `op_in` at all times.
- R9: With a function unit feeding `unit_result` from the two buses, an operation such as Rd <- Ra + Rb (or Ra + constant) completes in a single clock.
- R10: Reset takes precedence over a write requested at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| ctl | input | 9 | Control word {dest[1:0], asel[1:0], bsel[1:0], use_const, use_ext, write} |
| op_in | input | OPW | Function-select code for the external unit |
| const_in | input | W | Constant for the B operand |
| ext_in | input | W | External write-back data |
| unit_result | input | W | Result returned by the function unit |
| unit_op | output | OPW | Function-select code passed to the unit |
| opa_bus | output | W | A operand bus |
| opb_bus | output | W | B operand bus |
| wb_bus | output | W | Write-back bus |

## Verification
The hardest situation to reach is a register being both source and destination in the same cycle, because the old and new values differ only across one edge and the function unit's result depends on the old one. The bench attaches an adder that computes the result from the two buses, selects the same register as A source and destination, samples the A bus before the edge to see the old value and after it to see the sum, and also drives reset and a write together to show that reset wins.

// File: rtl/sc_regpath.sv
module sc_regpath #(
  parameter int W   = 8,
  parameter int OPW = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [8:0]     ctl,
  input  logic [OPW-1:0] op_in,
  input  logic [W-1:0]   const_in,
  input  logic [W-1:0]   ext_in,
  input  logic [W-1:0]   unit_result,
  output logic [OPW-1:0] unit_op,
  output logic [W-1:0]   opa_bus,
  output logic [W-1:0]   opb_bus,
  output logic [W-1:0]   wb_bus
);
  localparam int NREG = 4;

  logic [1:0] dest, asel, bsel;
  logic       use_const, use_ext, wr;
  logic [NREG-1:0][W-1:0] rf;

  assign {dest, asel, bsel, use_const, use_ext, wr} = ctl;

  assign unit_op = op_in;
  assign opa_bus = rf[asel];
  assign opb_bus = use_const ? const_in : rf[bsel];
  assign wb_bus  = use_ext ? ext_in : unit_result;

  for (genvar i = 0; i < NREG; i++) begin : g_rf
    always_ff @(posedge clk) begin
      if (rst)
        rf[i] <= '0;
      else if (wr && dest == i[1:0])
        rf[i] <= wb_bus;
    end
  end
endmodule

module sc_regpath_chk #(
  parameter int W = 8
) (
  input logic                clk,
  input logic                rst,
  input logic [8:0]          ctl,
  input logic [W-1:0]        ext_in,
  input logic [W-1:0]        wb_bus,
  input logic [3:0][W-1:0]   rf
);
  a_r1_reset_clear: assert property (@(posedge clk) rst |=> rf == '0);

  for (genvar i = 0; i < 4; i++) begin : g_chk
    a_r5_load: assert property (@(posedge clk) disable iff (rst)
      (ctl[0] && ctl[8:7] == i[1:0]) |=> rf[i] == $past(wb_bus));
    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
      !(ctl[0] && ctl[8:7] == i[1:0]) |=> rf[i] == $past(rf[i]));
    a_r4_ext_load: assert property (@(posedge clk) disable iff (rst)
      (ctl[0] && ctl[1] && ctl[8:7] == i[1:0]) |=> rf[i] == $past(ext_in));
  end
endmodule

bind sc_regpath sc_regpath_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .ctl(ctl), .ext_in(ext_in), .wb_bus(wb_bus), .rf(rf)
);

// File: tb/sc_regpath_test.sv
`timescale 1ns/1ps
module sc_regpath_test;
  localparam int W = 8;
  localparam int OPW = 4;

  logic clk = 0, rst = 1;
  logic [8:0] ctl = '0;
  logic [OPW-1:0] op_in = '0, unit_op;
  logic [W-1:0] const_in = '0, ext_in = '0, manual = '0;
  logic [W-1:0] opa_bus, opb_bus, wb_bus, unit_result;
  logic use_add = 0;
  int checks = 0, fails = 0;

  assign unit_result = use_add ? opa_bus + opb_bus : manual;

  sc_regpath #(.W(W), .OPW(OPW)) uut (
    .clk(clk), .rst(rst), .ctl(ctl), .op_in(op_in), .const_in(const_in),
    .ext_in(ext_in), .unit_result(unit_result), .unit_op(unit_op),
    .opa_bus(opa_bus), .opb_bus(opb_bus), .wb_bus(wb_bus)
  );

  always #2.5 clk = ~clk;

  function automatic logic [8:0] cw(input logic [1:0] d, a, b,
                                    input logic mb, md, w);
    return {d, a, b, mb, md, w};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_ext(input logic [1:0] d, input logic [W-1:0] v);
    @(negedge clk);
    ctl = cw(d, 2'd0, 2'd0, 1'b0, 1'b1, 1'b1);
    ext_in = v;
    @(negedge clk);
    ctl = '0;
  endtask

  task automatic rd_a(input logic [1:0] a, output logic [W-1:0] v);
    @(negedge clk);
    ctl = cw(2'd0, a, 2'd0, 1'b0, 1'b0, 1'b0);
    #1 v = opa_bus;
  endtask

  task automatic t_reset;
    logic [W-1:0] v;
    for (int i = 0; i < 4; i++) begin
      rd_a(i[1:0], v);
      chk("R1 reset value", v, 0);
    end
  endtask

  task automatic t_write_read;
    logic [W-1:0] v;
    for (int i = 0; i < 4; i++) wr_ext(i[1:0], 8'h11 * (i + 1));
    for (int i = 0; i < 4; i++) begin
      rd_a(i[1:0], v);
      chk("R5/R2 write then A-bus read", v, 8'h11 * (i + 1));
    end
  endtask

  task automatic t_no_write;
    logic [W-1:0] v;
    @(negedge clk);
    ctl = cw(2'd2, 2'd0, 2'd0, 1'b0, 1'b1, 1'b0);
    ext_in = 8'hFF;
    @(negedge clk);
    ctl = '0;
    rd_a(2'd2, v);
    chk("R6 write bit low keeps register", v, 8'h33);
    wr_ext(2'd3, 8'hC3);
    rd_a(2'd0, v);
    chk("R6 unaddressed register kept", v, 8'h11);
    rd_a(2'd3, v);
    chk("R5 addressed register loaded", v, 8'hC3);
  endtask

  task automatic t_b_path;
    @(negedge clk);
    const_in = 8'h5A;
    for (int i = 0; i < 4; i++) begin
      ctl = cw(2'd0, 2'd0, i[1:0], 1'b0, 1'b0, 1'b0);
      #1 chk("R3 B bus from register", opb_bus, (i == 3) ? 8'hC3 : 8'h11 * (i + 1));
    end
    ctl = cw(2'd0, 2'd0, 2'd1, 1'b1, 1'b0, 1'b0);
    #1 chk("R3 B bus from constant", opb_bus, 8'h5A);
  endtask

  task automatic t_d_mux;
    logic [W-1:0] v;
    @(negedge clk);
    ext_in = 8'hE7; manual = 8'h3C;
    ctl = cw(2'd0, 2'd0, 2'd0, 1'b0, 1'b1, 1'b0);
    #1 chk("R4 wb from external", wb_bus, 8'hE7);
    ctl = cw(2'd0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0);
    #1 chk("R4 wb from unit result", wb_bus, 8'h3C);
    ctl = cw(2'd3, 2'd0, 2'd0, 1'b0, 1'b0, 1'b1);
    @(negedge clk);
    ctl = '0;
    rd_a(2'd3, v);
    chk("R4 unit result written back", v, 8'h3C);
  endtask

  task automatic t_read_during_write;
    @(negedge clk);
    ext_in = 8'h99;
    ctl = cw(2'd1, 2'd1, 2'd0, 1'b0, 1'b1, 1'b1);
    #1 chk("R7 old value before edge", opa_bus, 8'h22);
    @(posedge clk);
    #1 chk("R7 new value after edge", opa_bus, 8'h99);
    @(negedge clk);
    ctl = '0;
  endtask

  task automatic t_single_cycle;
    logic [W-1:0] v;
    wr_ext(2'd2, 8'h30);
    wr_ext(2'd3, 8'h0F);
    @(negedge clk);
    use_add = 1;
    ctl = cw(2'd1, 2'd2, 2'd3, 1'b0, 1'b0, 1'b1);
    @(posedge clk);
    #1 begin
      ctl = cw(2'd0, 2'd1, 2'd0, 1'b0, 1'b0, 1'b0);
      #0.5 chk("R9 R1 <- R2 + R3 in one clock", opa_bus, 8'h3F);
    end
    @(negedge clk);
    const_in = 8'h01;
    ctl = cw(2'd1, 2'd1, 2'd0, 1'b1, 1'b0, 1'b1);
    @(negedge clk);
    ctl = '0;
    use_add = 0;
    rd_a(2'd1, v);
    chk("R9 R1 <- R1 + constant", v, 8'h40);
  endtask

  task automatic t_opcode;
    for (int i = 0; i < 16; i += 5) begin
      @(negedge clk);
      op_in = i[OPW-1:0];
      #1 chk("R8 op passthrough", unit_op, i);
    end
  endtask

  task automatic t_reset_priority;
    logic [W-1:0] v;
    @(negedge clk);
    rst = 1;
    ext_in = 8'hAA;
    ctl = cw(2'd0, 2'd0, 2'd0, 1'b0, 1'b1, 1'b1);
    @(negedge clk);
    rst = 0;
    ctl = '0;
    for (int i = 0; i < 4; i++) begin
      rd_a(i[1:0], v);
      chk("R10/R1 reset over write", v, 0);
    end
  endtask

  initial begin
    #(5.0 * 100000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 0;
    t_reset();
    t_write_read();
    t_no_write();
    t_b_path();
    t_d_mux();
    t_read_during_write();
    t_single_cycle();
    t_opcode();
    t_reset_priority();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule